// File: doc/BRIEF.md
# Scaled-Index Load Address Generator

This block forms the effective address of a register-indexed load whose index operand is scaled by a left shift. Each request carries the base register value, the base and target register numbers, the index register value, a two-bit scale code and a flag marking the update form. The index is shifted left by the scale code plus one, so the index is scaled by 2, 4, 8 or 16, and then added to the base term. The sum wraps at the address width.

In the plain form, base register number 0 stands for a literal zero rather than the register's contents. In the update form the register contents are always used, and the finished address is sent back to the base register as a one-cycle write-back request. An update form whose base register number is 0, or equals the target register number, is reported as illegal and makes no write-back. All results are registered: they appear one cycle after the request and the address holds until the next request.

Top module: `sidx_agen`

## Requirements
- R1: `effAddr` equals the base term plus `indexVal` shifted left by (`shiftSel` + 1) positions, modulo 2^64; index bits shifted past bit 63 are lost (`shiftSel` 0,1,2,3 gives shifts of 1,2,3,4).
- R2: In the plain form (`isUpdate`=0) a `baseRegNum` of 0 makes the base term zero, whatever `baseVal` holds.
- R3: In the update form (`isUpdate`=1) the base term is always `baseVal`, including when `baseRegNum` is 0.
- R4: A legal update request raises `wbValid` for exactly one cycle, with `wbRegNum` equal to `baseRegNum` and `wbAddr` equal to `effAddr`.
- R5: A plain-form request never raises `wbValid`.
- R6: An update request with `baseRegNum` equal to 0 or equal to `targetRegNum` raises `illegalForm` and no write-back; legal requests leave `illegalForm` at 0.
- R7: Outputs follow a request by one clock cycle: `outValid` is high for one cycle per request, and `effAddr` keeps its value while no request arrives.
- R8: During and right after reset `outValid`, `wbValid` and `illegalForm` are 0 and `effAddr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present this cycle |
| isUpdate | input | 1 | 1 = update form, 0 = plain form |
| baseRegNum | input | 5 | Base register number |
| targetRegNum | input | 5 | Load target register number |
| baseVal | input | 64 | Base register contents |
| indexVal | input | 64 | Index register contents |
| shiftSel | input | 2 | Scale code, shift = code + 1 |
| outValid | output | 1 | Result valid, one cycle per request |
| effAddr | output | 64 | Effective address |
| illegalForm | output | 1 | Request was an illegal update form |
| wbValid | output | 1 | Write-back request to the base register |
| wbRegNum | output | 5 | Register written by the write-back |
| wbAddr | output | 64 | Value written by the write-back |

## Verification
The assertions assume that the request fields are stable and defined in any cycle where `inValid` is high, and that reset is held for at least one clock edge before the first request. The stimulus changes inputs only at the falling edge, always drives every field, and drops `inValid` between requests so that each result and its one-cycle pulses can be seen alone. The random register numbers are drawn so that a zero base and a base equal to the target both come up often in update requests.

// File: rtl/sidx_pkg.sv
package sidx_pkg;
  // Strobes passed from control to datapath for one request.
  typedef struct packed {
    logic capture;   // register a new address this edge
    logic zeroBase;  // replace the base term with zero
  } sidxStrobes_t;
endpackage

// File: rtl/sidx_ctrl.sv
module sidx_ctrl
  import sidx_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             isUpdate,
  input  logic [REG_W-1:0] baseRegNum,
  input  logic [REG_W-1:0] targetRegNum,
  output sidxStrobes_t     strobes,
  output logic             outValid,
  output logic             wbValid,
  output logic             illegalForm
);
  logic baseIsZero;
  logic badUpdate;
  logic goodUpdate;

  assign baseIsZero = (baseRegNum == '0);
  assign badUpdate  = isUpdate && (baseIsZero || (baseRegNum == targetRegNum));
  assign goodUpdate = isUpdate && !badUpdate;

  always_comb begin
    strobes          = '0;
    strobes.capture  = inValid;
    strobes.zeroBase = baseIsZero && !isUpdate;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      wbValid     <= 1'b0;
      illegalForm <= 1'b0;
    end else begin
      outValid    <= inValid;
      wbValid     <= inValid && goodUpdate;
      illegalForm <= inValid && badUpdate;
    end
  end

  // R6: an illegal form never writes back
  a_r6_illegal_no_wb: assert property (@(posedge clk) disable iff (!rstN)
    illegalForm |-> !wbValid);

  // R4: a write-back only comes with a valid result
  a_r4_wb_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> outValid);

  // R5: plain forms raise no write-back
  a_r5_plain_no_wb: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !isUpdate) |=> !wbValid);

  // R7: no result without a request
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && !wbValid && !illegalForm));
endmodule

// File: rtl/sidx_dp.sv
module sidx_dp
  import sidx_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int SH_W   = 2,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  sidxStrobes_t      strobes,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] indexVal,
  input  logic [SH_W-1:0]   shiftSel,
  input  logic [REG_W-1:0]  baseRegNum,
  output logic [ADDR_W-1:0] effAddr,
  output logic [REG_W-1:0]  wbRegNum
);
  localparam int SHAMT_W = $clog2(ADDR_W) + 1;

  logic [SHAMT_W-1:0] shiftAmt;
  logic [ADDR_W-1:0]  scaledIdx;
  logic [ADDR_W-1:0]  baseTerm;
  logic [ADDR_W-1:0]  sumAddr;

  assign shiftAmt  = SHAMT_W'(shiftSel) + SHAMT_W'(1);
  assign scaledIdx = indexVal << shiftAmt;
  assign baseTerm  = strobes.zeroBase ? '0 : baseVal;
  assign sumAddr   = baseTerm + scaledIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      effAddr  <= '0;
      wbRegNum <= '0;
    end else if (strobes.capture) begin
      effAddr  <= sumAddr;
      wbRegNum <= baseRegNum;
    end
  end

  // R2: a zero base leaves only the scaled index, whose low bit is always 0
  a_r2_zero_base_even: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && strobes.zeroBase) |=> (effAddr[0] == 1'b0));

  // R7: the address holds while no request arrives
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(effAddr));
endmodule

// File: rtl/sidx_agen.sv
module sidx_agen
  import sidx_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int SH_W   = 2,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              isUpdate,
  input  logic [REG_W-1:0]  baseRegNum,
  input  logic [REG_W-1:0]  targetRegNum,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] indexVal,
  input  logic [SH_W-1:0]   shiftSel,
  output logic              outValid,
  output logic [ADDR_W-1:0] effAddr,
  output logic              illegalForm,
  output logic              wbValid,
  output logic [REG_W-1:0]  wbRegNum,
  output logic [ADDR_W-1:0] wbAddr
);
  sidxStrobes_t strobes;

  sidx_ctrl #(.REG_W(REG_W)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .isUpdate     (isUpdate),
    .baseRegNum   (baseRegNum),
    .targetRegNum (targetRegNum),
    .strobes      (strobes),
    .outValid     (outValid),
    .wbValid      (wbValid),
    .illegalForm  (illegalForm)
  );

  sidx_dp #(.ADDR_W(ADDR_W), .SH_W(SH_W), .REG_W(REG_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .baseVal    (baseVal),
    .indexVal   (indexVal),
    .shiftSel   (shiftSel),
    .baseRegNum (baseRegNum),
    .effAddr    (effAddr),
    .wbRegNum   (wbRegNum)
  );

  assign wbAddr = effAddr;

  // R4: a write-back names a nonzero register
  a_r4_wb_reg_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (wbRegNum != '0));

  // R4: the write-back pulse lasts one cycle unless a new request followed
  a_r4_wb_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !inValid) |=> !wbValid);
endmodule

// File: tb/test_sidx_agen.sv
module test_sidx_agen;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic        isUpdate;
  logic [4:0]  baseRegNum;
  logic [4:0]  targetRegNum;
  logic [63:0] baseVal;
  logic [63:0] indexVal;
  logic [1:0]  shiftSel;
  logic        outValid;
  logic [63:0] effAddr;
  logic        illegalForm;
  logic        wbValid;
  logic [4:0]  wbRegNum;
  logic [63:0] wbAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  sidx_agen i_sidx_agen (
    .clk(clk), .rstN(rstN), .inValid(inValid), .isUpdate(isUpdate),
    .baseRegNum(baseRegNum), .targetRegNum(targetRegNum),
    .baseVal(baseVal), .indexVal(indexVal), .shiftSel(shiftSel),
    .outValid(outValid), .effAddr(effAddr), .illegalForm(illegalForm),
    .wbValid(wbValid), .wbRegNum(wbRegNum), .wbAddr(wbAddr)
  );

  function automatic logic [63:0] expAddr(logic upd, logic [4:0] rb,
                                          logic [63:0] bv, logic [63:0] iv,
                                          logic [1:0] sh);
    logic [63:0] b;
    b = (!upd && rb == 5'd0) ? 64'd0 : bv;
    return b + (iv << (int'(sh) + 1));
  endfunction

  function automatic logic expIllegal(logic upd, logic [4:0] rb, logic [4:0] rt);
    return upd && (rb == 5'd0 || rb == rt);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doOp(logic upd, logic [4:0] rb, logic [4:0] rt,
                      logic [63:0] bv, logic [63:0] iv, logic [1:0] sh);
    logic [63:0] ea;
    logic        ill;
    logic        wb;
    ea  = expAddr(upd, rb, bv, iv, sh);
    ill = expIllegal(upd, rb, rt);
    wb  = upd && !ill;
    inValid = 1'b1; isUpdate = upd; baseRegNum = rb; targetRegNum = rt;
    baseVal = bv; indexVal = iv; shiftSel = sh;
    @(negedge clk);
    inValid  = 1'b0;
    baseVal  = ~bv;
    indexVal = ~iv;
    chk("R7 outValid", 64'(outValid), 64'd1);
    chk(upd ? "R1/R3 effAddr" : "R1/R2 effAddr", effAddr, ea);
    chk("R6 illegalForm", 64'(illegalForm), 64'(ill));
    chk(upd ? "R4 wbValid" : "R5 wbValid", 64'(wbValid), 64'(wb));
    if (wb) begin
      chk("R4 wbRegNum", 64'(wbRegNum), 64'(rb));
      chk("R4 wbAddr", wbAddr, ea);
    end
    @(negedge clk);
    chk("R7 outValid drop", 64'(outValid), 64'd0);
    chk("R4 wbValid one cycle", 64'(wbValid), 64'd0);
    chk("R7 effAddr hold", effAddr, ea);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] bv;
    logic [63:0] iv;
    logic [4:0]  rb;
    logic [4:0]  rt;
    void'($urandom(32'h5eed_1234));
    rstN = 1'b0; inValid = 1'b0; isUpdate = 1'b0; baseRegNum = '0;
    targetRegNum = '0; baseVal = '0; indexVal = '0; shiftSel = '0;
    repeat (3) @(negedge clk);
    chk("R8 outValid reset", 64'(outValid), 64'd0);
    chk("R8 wbValid reset", 64'(wbValid), 64'd0);
    chk("R8 illegalForm reset", 64'(illegalForm), 64'd0);
    chk("R8 effAddr reset", effAddr, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R8 effAddr after reset", effAddr, 64'd0);

    // R1: each shift code
    for (int s = 0; s < 4; s++)
      doOp(1'b0, 5'd3, 5'd4, 64'h1000, 64'h1, 2'(s));
    // R1: wrap of the sum and loss of top index bits
    doOp(1'b0, 5'd7, 5'd8, 64'hFFFF_FFFF_FFFF_FFF0, 64'h10, 2'd0);
    doOp(1'b0, 5'd7, 5'd8, 64'h0, 64'hF000_0000_0000_0001, 2'd3);
    // R2: zero base field in plain form ignores baseVal
    doOp(1'b0, 5'd0, 5'd9, 64'hDEAD_BEEF_0000_0001, 64'h40, 2'd1);
    // R3/R6: zero base field in update form uses baseVal and is illegal
    doOp(1'b1, 5'd0, 5'd9, 64'hDEAD_BEEF_0000_0001, 64'h40, 2'd1);
    // R6: base equal to target in update form
    doOp(1'b1, 5'd12, 5'd12, 64'h2000, 64'h3, 2'd2);
    // R4: legal update
    doOp(1'b1, 5'd31, 5'd1, 64'h8000_0000_0000_0000, 64'h7, 2'd3);
    // R5: plain form with base equal to target is legal, no write-back
    doOp(1'b0, 5'd12, 5'd12, 64'h2000, 64'h3, 2'd2);

    for (int n = 0; n < 400; n++) begin
      bv = {$urandom, $urandom};
      iv = {$urandom, $urandom};
      rb = 5'($urandom_range(0, 3) == 0 ? 0 : $urandom_range(1, 31));
      rt = ($urandom_range(0, 3) == 0) ? rb : 5'($urandom_range(0, 31));
      doOp(1'($urandom_range(0, 1)), rb, rt, bv, iv, 2'($urandom_range(0, 3)));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule